// File: doc/BRIEF.md
# Extended Flat Program-ROM Address Decoder

This block turns a 16-bit CPU address into a program-ROM chip select and a 16-bit ROM address for a cartridge whose ROM is larger than the usual 32 KiB window. No bank register is involved. The upper half of the CPU map ($8000-$FFFF) reaches the first 32 KiB of the ROM. An extra 14 KiB window ($4800-$7FFF) reaches the top of the ROM. Software therefore sees one contiguous, permanently visible program space of 46 KiB.

The ROM address is the CPU address with its most significant bit inverted. The select comes from one magnitude comparison against a threshold, built as a cascade of small compare slices. It is qualified by the read strobe and the phase-2 clock. The threshold keeps the bottom 2 KiB of the $4000 page, and everything below it, off the ROM. This leaves the on-chip I/O registers at $4000-$401F unshadowed. ROM offsets $8000-$C7FF can never be selected and hold padding.

The CPU bus runs near 2 MHz, so short decode glitches on the select are harmless. The combinational form is therefore acceptable. A registered form, chosen by parameter, delays both outputs by one clock and gives glitch-free outputs.

Top module: `flatrom_decoder`

## Requirements
- R1: A read (cpu_rw=1) with phi2=1 at any CPU address $8000-$FFFF drives rom_sel=1, and rom_addr equals the CPU address minus $8000 (offsets $0000-$7FFF).
- R2: A read with phi2=1 at any CPU address $4800-$7FFF drives rom_sel=1, and rom_addr equals the CPU address plus $8000 (offsets $C800-$FFFF).
- R3: For CPU addresses $4000-$47FF, rom_sel is 0 for every combination of cpu_rw and phi2.
- R4: For CPU addresses $0000-$3FFF, rom_sel is 0 for every combination of cpu_rw and phi2.
- R5: When cpu_rw=0 (write), rom_sel is 0 at every address.
- R6: When phi2=0, rom_sel is 0 at every address.
- R7: rom_addr equals the CPU address with bit 15 inverted for every input, whether or not rom_sel is asserted.
- R8: With REGISTERED=1, both outputs follow the inputs present at the previous rising clock edge. While rst_n=0, rom_sel=0 and rom_addr=$0000. With REGISTERED=0, the outputs follow the inputs with no clock delay.
- R9: rom_sel is never 1 while rom_addr lies in $8000-$C7FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset for the output registers |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Phase-2 bus qualifier, high while the data phase is valid |
| rom_sel | output | 1 | Program-ROM chip select, active high |
| rom_addr | output | 16 | ROM address |

## Verification
The bench builds two copies of the block at the default window threshold of $4800. One copy uses REGISTERED=1 and the other REGISTERED=0, so the same stimulus checks both the one-cycle delayed path with its reset values and the direct path. Both copies see every one of the 65536 addresses as a qualified read, which covers both region edges: $47FF/$4800 and $7FFF/$8000. A second pass mixes writes and phase-2-low cycles across all regions, so the read and phase qualifiers are tested apart from the address decode.

// File: rtl/flatrom_pkg.sv
package flatrom_pkg;
    localparam int CPU_AW  = 16;
    localparam int SLICE_W = 4;

    typedef struct packed {
        logic              sel;
        logic [CPU_AW-1:0] addr;
    } flatrom_out_t;
endpackage

// File: rtl/flatrom_cmp_slice.sv
module flatrom_cmp_slice #(
    parameter int SW = 4
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          gt_in,
    input  logic          eq_in,
    output logic          gt_out,
    output logic          eq_out
);
    always_comb begin
        gt_out = gt_in | (eq_in & (a > b));
        eq_out = eq_in & (a == b);
    end
endmodule

// File: rtl/flatrom_threshold.sv
module flatrom_threshold #(
    parameter int          AW     = 16,
    parameter int          SW     = 4,
    parameter logic [15:0] THRESH = 16'h4800
) (
    input  logic [AW-1:0] addr,
    output logic          at_or_above
);
    localparam int NSL = AW / SW;
    localparam logic [AW-1:0] TH = AW'(THRESH);

    logic [NSL:0] gt_c;
    logic [NSL:0] eq_c;

    assign gt_c[NSL] = 1'b0;
    assign eq_c[NSL] = 1'b1;

    for (genvar i = NSL - 1; i >= 0; i--) begin : g_slice
        flatrom_cmp_slice #(.SW(SW)) u_slice (
            .a      (addr[i*SW +: SW]),
            .b      (TH[i*SW +: SW]),
            .gt_in  (gt_c[i+1]),
            .eq_in  (eq_c[i+1]),
            .gt_out (gt_c[i]),
            .eq_out (eq_c[i])
        );
    end

    assign at_or_above = gt_c[0] | eq_c[0];
endmodule

// File: rtl/flatrom_addr_map.sv
module flatrom_addr_map #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cpu_addr,
    output logic [AW-1:0] rom_addr
);
    always_comb begin
        rom_addr         = cpu_addr;
        rom_addr[AW-1]   = ~cpu_addr[AW-1];
    end
endmodule

// File: rtl/flatrom_decoder.sv
module flatrom_decoder
    import flatrom_pkg::*;
#(
    parameter bit          REGISTERED = 1'b1,
    parameter logic [15:0] EXTRA_BASE = 16'h4800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              phi2,
    output logic              rom_sel,
    output logic [CPU_AW-1:0] rom_addr
);
    logic              in_window;
    logic [CPU_AW-1:0] mapped;
    flatrom_out_t      out_d;

    flatrom_threshold #(
        .AW     (CPU_AW),
        .SW     (SLICE_W),
        .THRESH (EXTRA_BASE)
    ) u_thresh (
        .addr        (cpu_addr),
        .at_or_above (in_window)
    );

    flatrom_addr_map #(.AW(CPU_AW)) u_map (
        .cpu_addr (cpu_addr),
        .rom_addr (mapped)
    );

    always_comb begin
        out_d      = '0;
        out_d.sel  = in_window & cpu_rw & phi2;
        out_d.addr = mapped;
    end

    if (REGISTERED) begin : g_reg
        flatrom_out_t out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
        assign rom_sel  = out_q.sel;
        assign rom_addr = out_q.addr;
    end else begin : g_comb
        assign rom_sel  = out_d.sel;
        assign rom_addr = out_d.addr;
    end
endmodule

// File: rtl/flatrom_decoder_chk.sv
module flatrom_decoder_chk #(
    parameter bit          REGISTERED = 1'b1,
    parameter logic [15:0] EXTRA_BASE = 16'h4800
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rw,
    input logic        phi2,
    input logic        rom_sel,
    input logic [15:0] rom_addr
);
    localparam logic [15:0] PAD_END = 16'h8000 | EXTRA_BASE;

    AST_NO_PAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr < 16'h8000 || rom_addr >= PAD_END)); // R9

    if (REGISTERED) begin : g_reg
        AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            rom_sel |-> $past(cpu_rw)); // R5
        AST_PHI2_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            rom_sel |-> $past(phi2)); // R6
        AST_BELOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            rom_sel |-> ($past(cpu_addr) >= EXTRA_BASE)); // R3
        AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cpu_addr) < 16'h4000) |-> !rom_sel); // R4
        AST_ADDR_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (rom_addr[14:0] == $past(cpu_addr[14:0]))); // R7
        AST_ADDR_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (rom_addr[15] != $past(cpu_addr[15]))); // R7
        AST_UPPER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cpu_rw) && $past(phi2) && $past(cpu_addr[15]))
            |-> rom_sel); // R1
    end else begin : g_comb
        AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            rom_sel |-> cpu_rw); // R5
        AST_PHI2_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            rom_sel |-> phi2); // R6
        AST_BELOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            rom_sel |-> (cpu_addr >= EXTRA_BASE)); // R3
        AST_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_addr < 16'h4000) |-> !rom_sel); // R4
        AST_ADDR_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            rom_addr[14:0] == cpu_addr[14:0]); // R7
        AST_ADDR_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            rom_addr[15] != cpu_addr[15]); // R7
        AST_UPPER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_rw && phi2 && cpu_addr[15]) |-> rom_sel); // R1
    end
endmodule

bind flatrom_decoder flatrom_decoder_chk #(
    .REGISTERED (REGISTERED),
    .EXTRA_BASE (EXTRA_BASE)
) u_chk (.*);

// File: tb/flatrom_decoder_tb.sv
module flatrom_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b0;
    logic        phi2 = 1'b0;
    logic        sel_r, sel_c;
    logic [15:0] addr_r, addr_c;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    flatrom_decoder #(.REGISTERED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .phi2(phi2), .rom_sel(sel_r), .rom_addr(addr_r));

    flatrom_decoder #(.REGISTERED(1'b0)) u_comb (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .phi2(phi2), .rom_sel(sel_c), .rom_addr(addr_c));

    function automatic bit ref_sel(int a, bit rw, bit p2);
        return rw && p2 && (a >= 18432);
    endfunction

    function automatic int ref_addr(int a);
        if (a >= 32768) return a - 32768;
        return a + 32768;
    endfunction

    function automatic string sel_tag(int a, bit rw, bit p2);
        if (!rw)          return "R5";
        if (!p2)          return "R6";
        if (a < 16384)    return "R4";
        if (a < 18432)    return "R3";
        if (a < 32768)    return "R2";
        return "R1";
    endfunction

    task automatic compare(string who, int a, bit rw, bit p2,
                           logic s, logic [15:0] ra);
        bit es = ref_sel(a, rw, p2);
        int ea = ref_addr(a);
        checks++;
        if (s !== es) begin
            fails++;
            $display("FAIL %s %s addr=%h sel actual=%b expected=%b",
                     sel_tag(a, rw, p2), who, a[15:0], s, es);
        end
        checks++;
        if (ra !== 16'(ea)) begin
            fails++;
            $display("FAIL R7 %s addr=%h rom_addr actual=%h expected=%h",
                     who, a[15:0], ra, 16'(ea));
        end
        if (s === 1'b1 && ra >= 16'h8000 && ra < 16'hC800) begin
            fails++;
            $display("FAIL R9 %s rom_addr actual=%h expected outside 8000-C7FF",
                     who, ra);
        end
    endtask

    bit have_prev = 0;
    int prev_a;
    bit prev_rw, prev_p2;

    task automatic step(int a, bit rw, bit p2);
        @(negedge clk);
        if (have_prev) compare("R8 registered", prev_a, prev_rw, prev_p2, sel_r, addr_r);
        cpu_addr = 16'(a);
        cpu_rw   = rw;
        phi2     = p2;
        #1;
        compare("R8 direct", a, rw, p2, sel_c, addr_c);
        prev_a = a; prev_rw = rw; prev_p2 = p2; have_prev = 1;
    endtask

    initial begin
        #200000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cpu_addr = 16'hFFFF; cpu_rw = 1'b1; phi2 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (sel_r !== 1'b0 || addr_r !== 16'h0000) begin
            fails++;
            $display("FAIL R8 reset sel/addr actual=%b/%h expected=0/0000", sel_r, addr_r);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 65536; i++) step(i, 1'b1, 1'b1);
        for (int i = 0; i < 16384; i++) step(i * 4 + ((i >> 3) & 3), i[0], i[1]);
        step(16'h47FF, 1'b1, 1'b1);
        step(16'h4800, 1'b1, 1'b1);
        step(16'h7FFF, 1'b1, 1'b1);
        step(16'h8000, 1'b1, 1'b1);
        step(16'h4000, 1'b1, 1'b1);
        @(negedge clk);
        compare("R8 registered", prev_a, prev_rw, prev_p2, sel_r, addr_r);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule